// File: doc/BRIEF.md
# Dual-Reference Switchover Controller

This block watches two incoming reference clocks and decides, from a stable local clock, which one should feed the downstream PLL. Each reference passes through a two-flop synchronizer into an activity monitor. The monitor counts rising edges over a programmable window of local cycles and reports the reference as present or absent at the end of every window.

A selection state machine turns the two presence flags into a registered select line. It fails over to the remaining reference when the active one disappears. After a lost reference A recovers, it either returns to A or stays on B, as a policy input sets. When no reference can be used it enters holdover, and it leaves holdover on its own once a reference comes back. A manual mode lets a select pin name the reference. Every change of the select line is marked by a single-cycle event pulse.

Top module: `ref_switchover`

## Requirements
- R1: A reference is reported present at the end of a window of `cfg_window`+1 local cycles if at least `cfg_min_edges` synchronized rising edges arrived in that window. It is reported absent at the end of a window with fewer edges. The presence flags change only at window ends.
- R2: During and straight after reset, `holdover` is 1, `sel_b` is 0, both presence flags are 0 and `switch_evt` is 0.
- R3: In automatic mode, when only one reference is present, the controller makes that reference active. `sel_b` is 0 for reference A and 1 for reference B.
- R4: When both references become present in the same cycle from holdover, reference A is chosen.
- R5: When the active reference becomes absent and the other one is present, the controller switches to the other one. The active reference is always one that was present in the previous cycle.
- R6: While B is active and A is present, `cfg_revert`=1 returns the selection to A. With `cfg_revert`=0 the selection stays on B.
- R7: When neither reference is present, the controller enters holdover and raises `holdover`. `sel_b` keeps its value throughout holdover. Holdover ends by itself once any reference is present.
- R8: With `man_en`=1, the active reference follows `man_sel` (0 selects A, 1 selects B). If the chosen reference is absent, the controller enters holdover rather than using the other reference.
- R9: `switch_evt` is high for exactly the one cycle in which `sel_b` takes a new value, and at no other time.
- R10: `holdover` is 0 whenever a reference is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_a | input | 1 | Reference clock A, asynchronous |
| ref_b | input | 1 | Reference clock B, asynchronous |
| cfg_window | input | WIN_W | Window length minus one, in local cycles |
| cfg_min_edges | input | WIN_W | Minimum rising edges per window for presence |
| cfg_revert | input | 1 | 1: return to A after it recovers; 0: stay on B |
| man_en | input | 1 | 1: obey the select pin |
| man_sel | input | 1 | Manual choice, 0 = A, 1 = B |
| sel_b | output | 1 | Registered select, 0 = A, 1 = B |
| holdover | output | 1 | No reference in use |
| a_present | output | 1 | Reference A present |
| b_present | output | 1 | Reference B present |
| switch_evt | output | 1 | One-cycle pulse on each change of sel_b |

## Verification
The assertions assume that each reference toggles at less than half the local clock rate, so that the synchronizer does not lose edges. They also assume that the configuration inputs are held steady for at least a whole window before presence is judged. The stimulus drives both references from one local-clock divider with a six-cycle period. It changes the window and threshold only while the result it expects is many windows away. It waits several windows after every change before it samples the outputs.

// File: rtl/refsw_pkg.sv
// Shared types for the reference switchover controller.
// Assumes: nothing beyond standard SystemVerilog packages.
package refsw_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ON_A = 2'd1,
        ST_ON_B = 2'd2
    } sel_state_t;

    localparam int unsigned NUM_REFS = 2;
endpackage

// File: rtl/refsw_sync.sv
// Two-flop synchronizer that brings an asynchronous level into the local domain.
// Assumes: the input is stable long enough to be caught (slower than clk/2).
module refsw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/refsw_activity_mon.sv
// Activity monitor: counts synchronized rising edges of one reference over a
// programmable window and reports presence at the end of each window.
// Assumes: cfg_window and cfg_min_edges are held steady across a window.
module refsw_activity_mon #(
    parameter int unsigned WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [WIN_W-1:0] cfg_min_edges,
    output logic             present
);
    logic             ref_s;
    logic             ref_d;
    logic             rise;
    logic [WIN_W-1:0] win_cnt;
    logic [WIN_W-1:0] edge_cnt;
    logic [WIN_W:0]   tally;
    logic             win_end;

    refsw_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ref_in),
        .q_sync  (ref_s)
    );

    // Delay the synchronized level by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_s;
    end

    assign rise    = ref_s & ~ref_d;
    assign tally   = {1'b0, edge_cnt} + {{WIN_W{1'b0}}, rise};
    assign win_end = (win_cnt >= cfg_window);

    // Run the window timer and edge counter, and judge presence at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            present  <= 1'b0;
        end else if (win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            present  <= (tally >= {1'b0, cfg_min_edges});
        end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= tally[WIN_W-1:0];
        end
    end

    // R1: presence may change only on the cycle after a window has closed.
    assert_present_at_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(present) |-> $past(win_end));
endmodule

// File: rtl/refsw_select_fsm.sv
// Selection state machine: picks the active reference from the presence flags,
// the revert policy and the manual controls, and drives the registered select,
// holdover and switch-event outputs.
// Assumes: presence flags are synchronous to clk.
module refsw_select_fsm
    import refsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_p,
    input  logic b_p,
    input  logic cfg_revert,
    input  logic man_en,
    input  logic man_sel,
    output logic sel_b,
    output logic holdover,
    output logic switch_evt
);
    sel_state_t state_q;
    sel_state_t state_d;
    logic       sel_d;

    // Next-state choice from the presence flags, policy and manual controls.
    always_comb begin
        state_d = state_q;
        if (man_en) begin
            if (man_sel) state_d = b_p ? ST_ON_B : ST_HOLD;
            else         state_d = a_p ? ST_ON_A : ST_HOLD;
        end else begin
            unique case (state_q)
                ST_ON_A: if (!a_p) state_d = b_p ? ST_ON_B : ST_HOLD;
                ST_ON_B: begin
                    if (!b_p)                  state_d = a_p ? ST_ON_A : ST_HOLD;
                    else if (a_p && cfg_revert) state_d = ST_ON_A;
                end
                default: begin
                    if (a_p)      state_d = ST_ON_A;
                    else if (b_p) state_d = ST_ON_B;
                    else          state_d = ST_HOLD;
                end
            endcase
        end
    end

    // Select value implied by the next state; it is held while in holdover.
    always_comb begin
        if (state_d == ST_ON_B)      sel_d = 1'b1;
        else if (state_d == ST_ON_A) sel_d = 1'b0;
        else                         sel_d = sel_b;
    end

    // Register the state and every output so that none of them glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_HOLD;
            sel_b      <= 1'b0;
            holdover   <= 1'b1;
            switch_evt <= 1'b0;
        end else begin
            state_q    <= state_d;
            sel_b      <= sel_d;
            holdover   <= (state_d == ST_HOLD);
            switch_evt <= (sel_d != sel_b);
        end
    end

    // R9: an event pulse always comes with a new select value.
    assert_evt_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_evt |-> (sel_b != $past(sel_b)));
    // R9: every new select value comes with an event pulse.
    assert_change_has_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b != $past(sel_b)) |-> switch_evt);
    // R7: with both references gone, holdover follows on the next cycle.
    assert_hold_when_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_p && !b_p) |=> holdover);
    // R7: the select line does not move while in holdover.
    assert_sel_kept_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |-> (sel_b == $past(sel_b)));
    // R8: outside holdover, manual mode follows the select pin.
    assert_manual_obeyed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(man_en) && !holdover) |-> (sel_b == $past(man_sel)));
    // R5 / R10: the active reference was present in the cycle it was chosen.
    assert_active_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !holdover |-> (sel_b ? $past(b_p) : $past(a_p)));
endmodule

// File: rtl/ref_switchover.sv
// Top level of the dual-reference switchover controller: one activity monitor
// per reference feeding the selection state machine.
// Assumes: references toggle below half the local clock rate.
module ref_switchover
    import refsw_pkg::*;
#(
    parameter int unsigned WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_a,
    input  logic             ref_b,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [WIN_W-1:0] cfg_min_edges,
    input  logic             cfg_revert,
    input  logic             man_en,
    input  logic             man_sel,
    output logic             sel_b,
    output logic             holdover,
    output logic             a_present,
    output logic             b_present,
    output logic             switch_evt
);
    logic [NUM_REFS-1:0] refs;
    logic [NUM_REFS-1:0] pres;

    assign refs = {ref_b, ref_a};

    for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_mon
        refsw_activity_mon #(.WIN_W(WIN_W)) u_mon (
            .clk           (clk),
            .rst_n         (rst_n),
            .ref_in        (refs[gi]),
            .cfg_window    (cfg_window),
            .cfg_min_edges (cfg_min_edges),
            .present       (pres[gi])
        );
    end

    assign a_present = pres[0];
    assign b_present = pres[1];

    refsw_select_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_p        (pres[0]),
        .b_p        (pres[1]),
        .cfg_revert (cfg_revert),
        .man_en     (man_en),
        .man_sel    (man_sel),
        .sel_b      (sel_b),
        .holdover   (holdover),
        .switch_evt (switch_evt)
    );
endmodule

// File: tb/ref_switchover_bench.sv
// Scoreboard bench: the driver queues each expected select value before the
// stimulus that causes it; the monitor pops one entry on every switch event.
module ref_switchover_bench;
    localparam int WIN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_a, ref_b;
    logic [WIN_W-1:0] cfg_window = 8'd31;
    logic [WIN_W-1:0] cfg_min_edges = 8'd3;
    logic             cfg_revert = 1'b0;
    logic             man_en = 1'b0;
    logic             man_sel = 1'b0;
    logic             sel_b, holdover, a_present, b_present, switch_evt;

    logic en_a = 1'b0, en_b = 1'b0;
    logic tog = 1'b0;
    int   div = 0;
    int   checks = 0, failures = 0;
    bit   exp_q[$];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ref_switchover #(.WIN_W(WIN_W)) u_ref_switchover (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
        .cfg_window(cfg_window), .cfg_min_edges(cfg_min_edges),
        .cfg_revert(cfg_revert), .man_en(man_en), .man_sel(man_sel),
        .sel_b(sel_b), .holdover(holdover), .a_present(a_present),
        .b_present(b_present), .switch_evt(switch_evt)
    );

    // Reference generator: period of six local cycles, gated per reference.
    always @(negedge clk) begin
        if (div == 2) begin div <= 0; tog <= ~tog; end
        else div <= div + 1;
    end
    assign ref_a = en_a & tog;
    assign ref_b = en_b & tog;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_switch(input bit sel);
        exp_q.push_back(sel);
    endtask

    task automatic settle();
        repeat (160) @(negedge clk);
    endtask

    task automatic chk_state(input string req, input bit s, input bit h);
        chk(sel_b == s, {req, " sel_b"}, sel_b, s);
        chk(holdover == h, {req, " holdover"}, holdover, h);
    endtask

    // Monitor: every switch event must match the next queued select value (R9).
    always @(negedge clk) begin
        if (rst_n && switch_evt) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected switch", sel_b, -1);
            else begin
                automatic bit e = exp_q.pop_front();
                chk(sel_b == e, "R9 switch value", sel_b, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R2: reset state
        chk_state("R2", 1'b0, 1'b1);
        chk(a_present == 0 && b_present == 0, "R2 presence", {a_present, b_present}, 0);
        chk(switch_evt == 0, "R2 evt", switch_evt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R2 after release", 1'b0, 1'b1);

        // R4: both arrive together -> A, select unchanged so no event
        en_a = 1; en_b = 1; settle();
        chk(a_present && b_present, "R1 both present", {a_present, b_present}, 3);
        chk_state("R4", 1'b0, 1'b0);

        // R5: A fails, B takes over
        expect_switch(1'b1);
        en_a = 0; settle();
        chk(!a_present, "R1 A absent", a_present, 0);
        chk_state("R5", 1'b1, 1'b0);

        // R6: A returns with revert off -> stay on B
        en_a = 1; settle();
        chk_state("R6 stay", 1'b1, 1'b0);
        // R6: revert on -> back to A
        expect_switch(1'b0);
        cfg_revert = 1; settle();
        chk_state("R6 revert", 1'b0, 1'b0);

        // R7: both lost -> holdover, select kept
        en_a = 0; en_b = 0; settle();
        chk_state("R7 hold", 1'b0, 1'b1);
        // R3: only B returns -> leaves holdover onto B
        expect_switch(1'b1);
        en_b = 1; settle();
        chk_state("R3 B only", 1'b1, 1'b0);

        // R8: manual mode
        cfg_revert = 0; en_a = 1; settle();
        chk_state("R6 no revert", 1'b1, 1'b0);
        expect_switch(1'b0);
        man_en = 1; man_sel = 0; settle();
        chk_state("R8 manual A", 1'b0, 1'b0);
        expect_switch(1'b1);
        man_sel = 1; settle();
        chk_state("R8 manual B", 1'b1, 1'b0);
        en_b = 0; settle();
        chk_state("R8 absent -> hold", 1'b1, 1'b1);

        // R10: back to automatic, A present -> active, holdover cleared
        expect_switch(1'b0);
        man_en = 0; settle();
        chk_state("R10 auto A", 1'b0, 1'b0);

        // R1: raised threshold makes a running reference absent
        cfg_min_edges = 8'd20; settle();
        chk(!a_present, "R1 threshold", a_present, 0);
        chk_state("R7 threshold hold", 1'b0, 1'b1);
        cfg_min_edges = 8'd3; settle();
        chk(a_present, "R1 restored", a_present, 1);
        chk_state("R7 leave hold", 1'b0, 1'b0);

        chk(exp_q.size() == 0, "R9 missing switch", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule